// File: doc/BRIEF.md
# Microprogram Sequencer with Coded Jumps

This block is the control unit of a microcoded 32-bit load/store processor built around one shared bus. A six-bit microprogram counter addresses a read-only control store. Each control word carries seventeen datapath strobes, a three-bit jump kind and, for the kinds that need one, an absolute microaddress. The datapath itself (register file, ALU, memory address latch, instruction register) sits outside the block. The block only drives its strobes and reads back three conditions: the opcode held in the instruction register, a memory-busy flag and a zero flag from the A latch.

The next microaddress is picked by the jump kind in the current word. The choices are increment, stall on busy, return to the fetch entry, jump to the entry of the opcode's instruction group, and a conditional jump on zero in either sense. The control store holds the instruction-fetch routine and routines for register ALU ops, immediate ALU ops, loads, stores, branch-on-zero, branch-on-nonzero, relative jump, register jump, and the linking forms of both jumps. An opcode that matches no group behaves as a no-op.

Top module: `mseq_core`

## Requirements
- R1: While reset is low and on the first cycle after it, `upc` is 0 and `ctrl` carries the first fetch step: `reg_sel`=0 (PC), `en_reg`=1, `ld_ma`=1, all other bits 0.
- R2: Fetch runs through states 0,1,2,3. Their strobes are: MA from PC; IR from memory (en_mem, ld_ir); A from PC; PC written with A+4 (`alu_op`=2, en_alu, reg_wr, reg_sel 0).
- R3: A stall state (1, 13, 18) keeps `upc` unchanged while `mem_busy` is 1 and moves on to `upc`+1 in the first cycle it is 0.
- R4: After state 3 the counter loads the group entry for the opcode. The entries are: 0x00 to 4; 0x08..0x0F to 7; 0x23 (load) to 10; 0x2B (store) to 15; 0x04 (branch-on-zero) to 20; 0x05 (branch-on-nonzero) to 25; 0x02 to 30; 0x12 to 33; 0x03 to 35; 0x13 to 39.
- R5: Any other opcode sends the counter from state 3 back to 0.
- R6: Branch-on-zero: state 20 loads A from rf1. At state 21 the counter goes to 0 when `zero_flag` is 0 and to 22 when it is 1. States 22 to 24 then form PC+sext16 and return to 0.
- R7: Branch-on-nonzero: the same layout at 25..29, but at state 26 the counter goes to 0 when `zero_flag` is 1 and to 27 when it is 0.
- R8: Load (10..14) and store (15..19) each take A from rf1, B from sext16, then MA from A+B (`alu_op`=1). The load then writes rf2 from memory, stalling on busy. The store then drives memory from rf2 (`mem_wr`), stalling on busy. Both finish with an empty step that returns to 0.
- R9: The relative jump (30..32) forms PC+sext26 (`ext26`=1). The register jump (33,34) moves rf1 through A into PC. The linking forms (35..38, 39..42) first write the old PC through A into register 31 (`reg_sel`=4, `alu_op`=0).
- R10: `ctrl` bits are {alu_op[16:14], ext26[13], reg_sel[12:10], en_imm[9], en_alu[8], en_mem[7], en_reg[6], mem_wr[5], reg_wr[4], ld_ma[3], ld_b[2], ld_a[1], ld_ir[0]}. At most one of the four bus sources is on, and at most one of reg_wr/mem_wr is on, in every state.
- R11: The register ALU routine (4..6: A←rf1, B←rf2, rf3←func with `alu_op`=3) and the immediate routine (7..9: A←rf1, B←sext16, rf2←op with `alu_op`=4) each end by returning to 0.
- R12: The counter never holds a value above 42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_busy | input | 1 | Memory has not finished the current access |
| zero_flag | input | 1 | A latch holds zero |
| ctrl | output | 17 | Datapath strobes of the current microword |
| upc | output | 6 | Current microprogram counter |

## Verification
The bound checker watches these on every cycle: the reset entry, the fixed fetch order, stalling on busy in all three stall states, both senses of the branch test, the one-source bus rule, and the bound on the counter. Some behaviour can only be shown by the bench's scenarios: the full opcode-to-entry map, the fall-through for unknown opcodes, the exact strobe pattern of every microstate, and whole routines driven with random busy and zero timing.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int UPC_W  = 6;
    localparam int OPC_W  = 6;
    localparam int CTRL_W = 17;
    localparam int RS_W   = 3;
    localparam int AOP_W  = 3;

    // register select codes
    localparam logic [RS_W-1:0] RS_PC  = 3'd0;
    localparam logic [RS_W-1:0] RS_RF1 = 3'd1;
    localparam logic [RS_W-1:0] RS_RF2 = 3'd2;
    localparam logic [RS_W-1:0] RS_RF3 = 3'd3;
    localparam logic [RS_W-1:0] RS_R31 = 3'd4;

    // ALU function codes
    localparam logic [AOP_W-1:0] AOP_PASSA = 3'd0;
    localparam logic [AOP_W-1:0] AOP_ADD   = 3'd1;
    localparam logic [AOP_W-1:0] AOP_INC4  = 3'd2;
    localparam logic [AOP_W-1:0] AOP_FUNC  = 3'd3;
    localparam logic [AOP_W-1:0] AOP_IMMOP = 3'd4;

    // microstate map
    localparam logic [UPC_W-1:0] S_FETCH0 = 6'd0;
    localparam logic [UPC_W-1:0] S_FETCH1 = 6'd1;
    localparam logic [UPC_W-1:0] S_FETCH3 = 6'd3;
    localparam logic [UPC_W-1:0] S_ALU    = 6'd4;
    localparam logic [UPC_W-1:0] S_ALUI   = 6'd7;
    localparam logic [UPC_W-1:0] S_LOAD   = 6'd10;
    localparam logic [UPC_W-1:0] S_STORE  = 6'd15;
    localparam logic [UPC_W-1:0] S_BRZ    = 6'd20;
    localparam logic [UPC_W-1:0] S_BRNZ   = 6'd25;
    localparam logic [UPC_W-1:0] S_JREL   = 6'd30;
    localparam logic [UPC_W-1:0] S_JREG   = 6'd33;
    localparam logic [UPC_W-1:0] S_JLREL  = 6'd35;
    localparam logic [UPC_W-1:0] S_JLREG  = 6'd39;
    localparam logic [UPC_W-1:0] S_LAST   = 6'd42;

    // opcodes that select a group
    localparam logic [OPC_W-1:0] OP_ALU   = 6'h00;
    localparam logic [OPC_W-1:0] OP_JREL  = 6'h02;
    localparam logic [OPC_W-1:0] OP_JLREL = 6'h03;
    localparam logic [OPC_W-1:0] OP_BRZ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_BRNZ  = 6'h05;
    localparam logic [OPC_W-1:0] OP_JREG  = 6'h12;
    localparam logic [OPC_W-1:0] OP_JLREG = 6'h13;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;
    localparam logic [2:0]       OP_ALUI_HI = 3'b001;

    typedef enum logic [2:0] {
        JK_NEXT  = 3'd0,
        JK_SPIN  = 3'd1,
        JK_FETCH = 3'd2,
        JK_DISP  = 3'd3,
        JK_FEQZ  = 3'd4,
        JK_FNEZ  = 3'd5
    } jump_e;

    typedef struct packed {
        logic [AOP_W-1:0] alu_op;
        logic             ext26;
        logic [RS_W-1:0]  reg_sel;
        logic             en_imm;
        logic             en_alu;
        logic             en_mem;
        logic             en_reg;
        logic             mem_wr;
        logic             reg_wr;
        logic             ld_ma;
        logic             ld_b;
        logic             ld_a;
        logic             ld_ir;
    } ctrl_t;

    typedef struct packed {
        ctrl_t             ctrl;
        jump_e             jk;
        logic [UPC_W-1:0]  tgt;
    } uword_t;

    typedef struct packed {
        logic [UPC_W-1:0] upc;
    } seq_st_t;

    // micro-operation builders
    function automatic ctrl_t uo_rd_a(input logic [RS_W-1:0] rs);
        ctrl_t c = '0;
        c.en_reg = 1'b1; c.reg_sel = rs; c.ld_a = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_rd_b(input logic [RS_W-1:0] rs);
        ctrl_t c = '0;
        c.en_reg = 1'b1; c.reg_sel = rs; c.ld_b = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_rd_ma(input logic [RS_W-1:0] rs);
        ctrl_t c = '0;
        c.en_reg = 1'b1; c.reg_sel = rs; c.ld_ma = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_imm_b(input logic wide);
        ctrl_t c = '0;
        c.en_imm = 1'b1; c.ext26 = wide; c.ld_b = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_alu_reg(input logic [AOP_W-1:0] op,
                                         input logic [RS_W-1:0]  rs);
        ctrl_t c = '0;
        c.en_alu = 1'b1; c.alu_op = op; c.reg_sel = rs; c.reg_wr = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_alu_ma(input logic [AOP_W-1:0] op);
        ctrl_t c = '0;
        c.en_alu = 1'b1; c.alu_op = op; c.ld_ma = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_mem_ir();
        ctrl_t c = '0;
        c.en_mem = 1'b1; c.ld_ir = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_mem_reg(input logic [RS_W-1:0] rs);
        ctrl_t c = '0;
        c.en_mem = 1'b1; c.reg_sel = rs; c.reg_wr = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t uo_reg_mem(input logic [RS_W-1:0] rs);
        ctrl_t c = '0;
        c.en_reg = 1'b1; c.reg_sel = rs; c.mem_wr = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
    import mseq_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           word
);

    always_comb begin
        word      = '0;
        word.jk   = JK_FETCH;
        word.tgt  = S_FETCH0;
        case (addr)
            // instruction fetch
            6'd0:  begin word.ctrl = uo_rd_ma(RS_PC);               word.jk = JK_NEXT; end
            6'd1:  begin word.ctrl = uo_mem_ir();                   word.jk = JK_SPIN; end
            6'd2:  begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd3:  begin word.ctrl = uo_alu_reg(AOP_INC4, RS_PC);   word.jk = JK_DISP; end
            // register ALU
            6'd4:  begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd5:  begin word.ctrl = uo_rd_b(RS_RF2);               word.jk = JK_NEXT; end
            6'd6:  begin word.ctrl = uo_alu_reg(AOP_FUNC, RS_RF3);  word.jk = JK_FETCH; end
            // immediate ALU
            6'd7:  begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd8:  begin word.ctrl = uo_imm_b(1'b0);                word.jk = JK_NEXT; end
            6'd9:  begin word.ctrl = uo_alu_reg(AOP_IMMOP, RS_RF2); word.jk = JK_FETCH; end
            // load
            6'd10: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd11: begin word.ctrl = uo_imm_b(1'b0);                word.jk = JK_NEXT; end
            6'd12: begin word.ctrl = uo_alu_ma(AOP_ADD);            word.jk = JK_NEXT; end
            6'd13: begin word.ctrl = uo_mem_reg(RS_RF2);            word.jk = JK_SPIN; end
            6'd14: begin word.ctrl = '0;                            word.jk = JK_FETCH; end
            // store
            6'd15: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd16: begin word.ctrl = uo_imm_b(1'b0);                word.jk = JK_NEXT; end
            6'd17: begin word.ctrl = uo_alu_ma(AOP_ADD);            word.jk = JK_NEXT; end
            6'd18: begin word.ctrl = uo_reg_mem(RS_RF2);            word.jk = JK_SPIN; end
            6'd19: begin word.ctrl = '0;                            word.jk = JK_FETCH; end
            // branch when A is zero
            6'd20: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd21: begin word.ctrl = '0;                            word.jk = JK_FNEZ; end
            6'd22: begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd23: begin word.ctrl = uo_imm_b(1'b0);                word.jk = JK_NEXT; end
            6'd24: begin word.ctrl = uo_alu_reg(AOP_ADD, RS_PC);    word.jk = JK_FETCH; end
            // branch when A is nonzero
            6'd25: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd26: begin word.ctrl = '0;                            word.jk = JK_FEQZ; end
            6'd27: begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd28: begin word.ctrl = uo_imm_b(1'b0);                word.jk = JK_NEXT; end
            6'd29: begin word.ctrl = uo_alu_reg(AOP_ADD, RS_PC);    word.jk = JK_FETCH; end
            // relative jump
            6'd30: begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd31: begin word.ctrl = uo_imm_b(1'b1);                word.jk = JK_NEXT; end
            6'd32: begin word.ctrl = uo_alu_reg(AOP_ADD, RS_PC);    word.jk = JK_FETCH; end
            // register jump
            6'd33: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd34: begin word.ctrl = uo_alu_reg(AOP_PASSA, RS_PC);  word.jk = JK_FETCH; end
            // relative jump with link
            6'd35: begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd36: begin word.ctrl = uo_alu_reg(AOP_PASSA, RS_R31); word.jk = JK_NEXT; end
            6'd37: begin word.ctrl = uo_imm_b(1'b1);                word.jk = JK_NEXT; end
            6'd38: begin word.ctrl = uo_alu_reg(AOP_ADD, RS_PC);    word.jk = JK_FETCH; end
            // register jump with link
            6'd39: begin word.ctrl = uo_rd_a(RS_PC);                word.jk = JK_NEXT; end
            6'd40: begin word.ctrl = uo_alu_reg(AOP_PASSA, RS_R31); word.jk = JK_NEXT; end
            6'd41: begin word.ctrl = uo_rd_a(RS_RF1);               word.jk = JK_NEXT; end
            6'd42: begin word.ctrl = uo_alu_reg(AOP_PASSA, RS_PC);  word.jk = JK_FETCH; end
            default: begin word.ctrl = '0;                          word.jk = JK_FETCH; end
        endcase
    end

endmodule

// File: rtl/mseq_dispatch.sv
module mseq_dispatch
    import mseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic [UPC_W-1:0] entry
);

    always_comb begin
        entry = S_FETCH0;
        if (opcode[OPC_W-1:OPC_W-3] == OP_ALUI_HI) begin
            entry = S_ALUI;
        end else begin
            case (opcode)
                OP_ALU:   entry = S_ALU;
                OP_LOAD:  entry = S_LOAD;
                OP_STORE: entry = S_STORE;
                OP_BRZ:   entry = S_BRZ;
                OP_BRNZ:  entry = S_BRNZ;
                OP_JREL:  entry = S_JREL;
                OP_JREG:  entry = S_JREG;
                OP_JLREL: entry = S_JLREL;
                OP_JLREG: entry = S_JLREG;
                default:  entry = S_FETCH0;
            endcase
        end
    end

endmodule

// File: rtl/mseq_next.sv
module mseq_next
    import mseq_pkg::*;
(
    input  logic [UPC_W-1:0] upc,
    input  jump_e            jk,
    input  logic [UPC_W-1:0] tgt,
    input  logic [UPC_W-1:0] entry,
    input  logic             busy,
    input  logic             zero,
    output logic [UPC_W-1:0] nxt
);

    logic [UPC_W-1:0] inc;

    always_comb begin
        inc = upc + 1'b1;
        case (jk)
            JK_NEXT:  nxt = inc;
            JK_SPIN:  nxt = busy ? upc : inc;
            JK_FETCH: nxt = tgt;
            JK_DISP:  nxt = entry;
            JK_FEQZ:  nxt = zero ? tgt : inc;
            JK_FNEZ:  nxt = zero ? inc : tgt;
            default:  nxt = S_FETCH0;
        endcase
    end

endmodule

// File: rtl/mseq_core.sv
module mseq_core
    import mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              mem_busy,
    input  logic              zero_flag,
    output logic [CTRL_W-1:0] ctrl,
    output logic [UPC_W-1:0]  upc
);

    seq_st_t          st_d, st_q;
    uword_t           word;
    logic [UPC_W-1:0] entry;
    logic [UPC_W-1:0] nxt;

    mseq_rom u_rom (
        .addr (st_q.upc),
        .word (word)
    );

    mseq_dispatch u_disp (
        .opcode (opcode),
        .entry  (entry)
    );

    mseq_next u_next (
        .upc   (st_q.upc),
        .jk    (word.jk),
        .tgt   (word.tgt),
        .entry (entry),
        .busy  (mem_busy),
        .zero  (zero_flag),
        .nxt   (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upc = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.upc <= S_FETCH0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl = word.ctrl;
    assign upc  = st_q.upc;

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
    import mseq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  opcode,
    input logic              mem_busy,
    input logic              zero_flag,
    input logic [CTRL_W-1:0] ctrl,
    input logic [UPC_W-1:0]  upc
);

    ctrl_t c;
    assign c = ctrl_t'(ctrl);

    AST_RESET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upc == S_FETCH0)); // R1

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == S_FETCH0) |=> (upc == S_FETCH1)); // R2

    AST_SPIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((upc == 6'd1 || upc == 6'd13 || upc == 6'd18) && mem_busy) |=> $stable(upc)); // R3

    AST_SPIN_GO: assert property (@(posedge clk) disable iff (!rst_n)
        ((upc == 6'd1 || upc == 6'd13 || upc == 6'd18) && !mem_busy) |=> (upc == $past(upc) + 6'd1)); // R3

    AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == S_FETCH3 && opcode == 6'h3F) |=> (upc == S_FETCH0)); // R5

    AST_BRZ_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 6'd21) |=> (upc == ($past(zero_flag) ? 6'd22 : S_FETCH0))); // R6

    AST_BRNZ_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        (upc == 6'd26) |=> (upc == ($past(zero_flag) ? S_FETCH0 : 6'd27))); // R7

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c.en_imm, c.en_alu, c.en_mem, c.en_reg}) && $onehot0({c.reg_wr, c.mem_wr})); // R10

    AST_UPC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        upc <= S_LAST); // R12

endmodule

bind mseq_core mseq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (opcode),
    .mem_busy  (mem_busy),
    .zero_flag (zero_flag),
    .ctrl      (ctrl),
    .upc       (upc)
);

// File: tb/mseq_core_bench.sv
`timescale 1ns/1ps
module mseq_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic        mem_busy = 1'b0;
    logic        zero_flag = 1'b0;
    logic [16:0] ctrl;
    logic [5:0]  upc;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_upc = 6'd0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mseq_core u_mseq_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (opcode),
        .mem_busy  (mem_busy),
        .zero_flag (zero_flag),
        .ctrl      (ctrl),
        .upc       (upc)
    );

    // expected group entry (R4, R5)
    function automatic logic [5:0] grp(input logic [5:0] op);
        if (op[5:3] == 3'b001) return 6'd7;
        case (op)
            6'h00: return 6'd4;
            6'h23: return 6'd10;
            6'h2B: return 6'd15;
            6'h04: return 6'd20;
            6'h05: return 6'd25;
            6'h02: return 6'd30;
            6'h12: return 6'd33;
            6'h03: return 6'd35;
            6'h13: return 6'd39;
            default: return 6'd0;
        endcase
    endfunction

    function automatic logic [5:0] ref_next(input logic [5:0] s, input logic [5:0] op,
                                            input logic b, input logic z);
        case (s)
            6'd1, 6'd13, 6'd18: return b ? s : s + 6'd1;
            6'd3:  return grp(op);
            6'd21: return z ? 6'd22 : 6'd0;
            6'd26: return z ? 6'd0 : 6'd27;
            6'd6, 6'd9, 6'd14, 6'd19, 6'd24, 6'd29,
            6'd32, 6'd34, 6'd38, 6'd42: return 6'd0;
            default: return (s > 6'd42) ? 6'd0 : s + 6'd1;
        endcase
    endfunction

    // {alu_op, ext26, reg_sel, flags[9:0]} with flags = imm,alu,mem,reg,mwr,rwr,ma,b,a,ir
    function automatic logic [16:0] pk(input logic [2:0] a, input logic e,
                                       input logic [2:0] r, input logic [9:0] f);
        return {a, e, r, f};
    endfunction

    function automatic logic [16:0] ref_ctrl(input logic [5:0] s);
        case (s)
            6'd0:  return pk(3'd0, 1'b0, 3'd0, 10'b0001001000);
            6'd1:  return pk(3'd0, 1'b0, 3'd0, 10'b0010000001);
            6'd2, 6'd22, 6'd27, 6'd30, 6'd35, 6'd39:
                   return pk(3'd0, 1'b0, 3'd0, 10'b0001000010);
            6'd3:  return pk(3'd2, 1'b0, 3'd0, 10'b0100010000);
            6'd4, 6'd7, 6'd10, 6'd15, 6'd20, 6'd25, 6'd33, 6'd41:
                   return pk(3'd0, 1'b0, 3'd1, 10'b0001000010);
            6'd5:  return pk(3'd0, 1'b0, 3'd2, 10'b0001000100);
            6'd6:  return pk(3'd3, 1'b0, 3'd3, 10'b0100010000);
            6'd8, 6'd11, 6'd16, 6'd23, 6'd28:
                   return pk(3'd0, 1'b0, 3'd0, 10'b1000000100);
            6'd9:  return pk(3'd4, 1'b0, 3'd2, 10'b0100010000);
            6'd12, 6'd17: return pk(3'd1, 1'b0, 3'd0, 10'b0100001000);
            6'd13: return pk(3'd0, 1'b0, 3'd2, 10'b0010010000);
            6'd18: return pk(3'd0, 1'b0, 3'd2, 10'b0001100000);
            6'd24, 6'd29, 6'd32, 6'd38:
                   return pk(3'd1, 1'b0, 3'd0, 10'b0100010000);
            6'd31, 6'd37: return pk(3'd0, 1'b1, 3'd0, 10'b1000000100);
            6'd34, 6'd42: return pk(3'd0, 1'b0, 3'd0, 10'b0100010000);
            6'd36, 6'd40: return pk(3'd0, 1'b0, 3'd4, 10'b0100010000);
            default: return 17'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] s);
        if (s == 6'd4 || s == 6'd7 || s == 6'd10 || s == 6'd15 || s == 6'd20 ||
            s == 6'd25 || s == 6'd30 || s == 6'd33 || s == 6'd35 || s == 6'd39) return "R4";
        if (s <= 6'd3)  return "R2";
        if (s <= 6'd9)  return "R11";
        if (s <= 6'd19) return "R8";
        if (s <= 6'd24) return "R6";
        if (s <= 6'd29) return "R7";
        if (s <= 6'd42) return "R9";
        return "R12";
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string req);
        chk(upc == exp_upc, req, upc, exp_upc);
        chk(ctrl == ref_ctrl(exp_upc), "R10", ctrl, ref_ctrl(exp_upc));
    endtask

    task automatic tick(input logic [5:0] op, input logic b, input logic z);
        opcode = op; mem_busy = b; zero_flag = z;
        exp_upc = ref_next(exp_upc, op, b, z);
        @(negedge clk);
        chk_state(req_of(exp_upc));
    endtask

    task automatic fetch_to(input logic [5:0] op);
        tick(op, 1'b0, 1'b0);
        tick(op, 1'b0, 1'b0);
        tick(op, 1'b0, 1'b0);
        tick(op, 1'b0, 1'b0);
    endtask

    logic [5:0] ops [10] = '{6'h00, 6'h0A, 6'h23, 6'h2B, 6'h04,
                             6'h05, 6'h02, 6'h12, 6'h03, 6'h13};

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] op;
        void'($urandom(32'h5EED_1234));
        @(negedge clk); @(negedge clk);
        // R1: state held in reset
        chk(upc == 6'd0, "R1", upc, 0);
        chk(ctrl == 17'b000_0_000_0001001000, "R1", ctrl, 17'b000_0_000_0001001000);
        rst_n = 1'b1;
        exp_upc = 6'd0;
        chk_state("R1");

        // R2 + R5: unknown opcode runs fetch and returns to 0
        fetch_to(6'h3F);
        chk(upc == 6'd0, "R5", upc, 0);

        // R3: stall in fetch while busy
        tick(6'h23, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) tick(6'h23, 1'b1, 1'b0);
        chk(upc == 6'd1, "R3", upc, 1);
        tick(6'h23, 1'b0, 1'b0);
        chk(upc == 6'd2, "R3", upc, 2);
        tick(6'h23, 1'b0, 1'b0);
        tick(6'h23, 1'b0, 1'b0);
        chk(upc == 6'd10, "R4", upc, 10);
        // R8: load with busy memory
        tick(6'h23, 1'b0, 1'b0); tick(6'h23, 1'b0, 1'b0); tick(6'h23, 1'b0, 1'b0);
        tick(6'h23, 1'b1, 1'b0); tick(6'h23, 1'b1, 1'b0);
        chk(upc == 6'd13, "R3", upc, 13);
        tick(6'h23, 1'b0, 1'b0); tick(6'h23, 1'b0, 1'b0);
        chk(upc == 6'd0, "R8", upc, 0);

        // R6: branch-on-zero, not taken then taken
        fetch_to(6'h04);
        tick(6'h04, 1'b0, 1'b0); tick(6'h04, 1'b0, 1'b0);
        chk(upc == 6'd0, "R6", upc, 0);
        fetch_to(6'h04);
        tick(6'h04, 1'b0, 1'b1); tick(6'h04, 1'b0, 1'b1);
        chk(upc == 6'd22, "R6", upc, 22);
        for (int i = 0; i < 3; i++) tick(6'h04, 1'b0, 1'b0);
        chk(upc == 6'd0, "R6", upc, 0);

        // R7: branch-on-nonzero, zero set falls back to fetch
        fetch_to(6'h05);
        tick(6'h05, 1'b0, 1'b1); tick(6'h05, 1'b0, 1'b1);
        chk(upc == 6'd0, "R7", upc, 0);

        // R9: register jump with link writes r31
        fetch_to(6'h13);
        tick(6'h13, 1'b0, 1'b0);
        chk(ctrl[12:10] == 3'd4 && ctrl[4], "R9", ctrl, 17'h10);

        // random mix (R2..R12)
        for (int n = 0; n < 6000; n++) begin
            if (exp_upc == 6'd3)
                op = ($urandom % 8 == 0) ? 6'($urandom) : ops[$urandom % 10];
            else
                op = opcode;
            tick(op, ($urandom % 3) == 0, $urandom % 2);
            chk(upc <= 6'd42, "R12", upc, 42);
        end

        // R1: reset in the middle of a routine
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(upc == 6'd0, "R1", upc, 0);
        @(negedge clk);
        rst_n = 1'b1;
        exp_upc = 6'd0;
        chk_state("R1");
        fetch_to(6'h00);
        chk(upc == 6'd4, "R11", upc, 4);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule